// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a bus-programmed watchdog that only accepts servicing near the end of its timeout period. A down-counter starts from a programmed preload value. The counter moves one step on each cycle in which the timer tick input is high. Software first sets the preload, the window size and the reaction choice. It then arms the block by writing a 32-bit magic word to the control register. From that point the timer can be serviced only inside an open window, which is a power-of-two fraction of the period just before the counter runs out.

A service is a pair of writes to the key register. Completing a service before the window opens is a violation. Letting the counter run out is also a violation. A violation raises the selected reaction, reloads the counter and sets a sticky timed-out flag in the status register. The reaction is either a one-cycle interrupt pulse or a reset request that is held until reset.

The block is built around a three-state machine:
- `S_DISARMED` is the state after reset. It moves to `S_ARMED` on the arm write.
- `S_ARMED` is the running state. It moves to `S_PRIMED` on the first service key.
- `S_PRIMED` returns to `S_ARMED` in any of three cases: the second key arrives (accepted, or flagged as early), a wrong key arrives while the window is closed, or a violation occurs.
- Only reset returns the machine to `S_DISARMED`.

Top module: `window_watchdog`

## Requirements
- R1: After reset the block is disarmed. Control reads 0, status reads 0, the window register reads 0x50, both reaction outputs are low, and the count register reads 0xFFF shifted left by PRE_SHIFT.
- R2: Writing exactly 0xA98559DA to control (offset 0x00) arms the block, and control then reads 0xA98559DA. Any other value written to control leaves the block disarmed, with control reading 0.
- R3: Once armed, the block stays armed until reset. After arming, writes to control, preload (0x04), reaction (0x14) and window (0x18) have no effect.
- R4: The reload value is the 12-bit preload shifted left by PRE_SHIFT. While disarmed, the count register (0x10) shows the reload value. On arming, the counter loads the reload value. While armed, it falls by one on each cycle with tick_i high and holds when tick_i is low.
- R5: A service is a key-register (0x0C) write of 0x0000E51A followed by a key write of 0x0000A35C. If the second write finds the count below the window threshold, the counter reloads and no violation occurs.
- R6: The window threshold is the reload value shifted right by k. The encodings 0x50, 0x500, 0x5000, 0x50000 and 0x500000 give k = 1 to 5, and any other encoding gives k = 1. The window is open while count < threshold.
- R7: A second key that finds count >= threshold is a violation: the counter reloads and the reaction fires.
- R8: A tick while the count is 0, without an accepted service in the same cycle, is a violation and reloads the counter.
- R9: The second key with no first key before it does nothing. Any other word written to the key register while the window is closed cancels a pending first key. Such a word is ignored while the window is open. Neither case reloads the counter.
- R10: If the reaction register (low 4 bits) holds 0xA, a violation gives a one-cycle nmi_o pulse in the next cycle. Otherwise rst_req_o rises in the next cycle and stays high until reset.
- R11: Status bit 1 (offset 0x08) is set in the cycle after a violation. It stays set until a status write with bit 1 high clears it. If a violation and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer step enable |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| nmi_o | output | 1 | Interrupt reaction pulse |
| rst_req_o | output | 1 | Reset reaction level |

## Verification
The bench services at the first open count and again one count earlier, for every window size and for several preloads. A threshold check that is off by one, or a decoder that is wrong, would accept the early service or reject the first open one. It sends a lone second key, a wrong word while the window is closed, and a wrong word while it is open. A design that reloaded on these, or that treated them the same way in both cases, would show a count or flag that differs from the expected value. It also lets the counter expire under each reaction choice and tries to reconfigure and disarm the block after arming. A pulse that lingers, a reset request that drops, or a register that can still be written would show up at the outputs.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        S_DISARMED = 2'd0,
        S_ARMED    = 2'd1,
        S_PRIMED   = 2'd2
    } wd_state_t;

    localparam logic [DATA_W-1:0] ARM_WORD  = 32'hA98559DA;
    localparam logic [DATA_W-1:0] KEY_FIRST = 32'h0000E51A;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'h0000A35C;
    localparam logic [3:0]        REACT_NMI = 4'hA;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PRE   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_KEY   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_REACT = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_WIN   = 8'h18;

    localparam logic [DATA_W-1:0] WIN_RESET = 32'h00000050;

    // Right-shift amount for the window threshold; unknown codes fall to half.
    function automatic logic [2:0] win_shift(input logic [DATA_W-1:0] enc);
        logic [2:0] k;
        case (enc)
            32'h00000050: k = 3'd1;
            32'h00000500: k = 3'd2;
            32'h00005000: k = 3'd3;
            32'h00050000: k = 3'd4;
            32'h00500000: k = 3'd5;
            default:      k = 3'd1;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/wwd_counter.sv
module wwd_counter #(
    parameter int              CNT_W   = 25,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= RST_VAL;
        else if (load_i)
            cnt_q <= reload_i;
        else if (tick_i && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

    // R4: one step down per tick when not reloading
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && tick_i && !zero_o) |=> (cnt_o == $past(cnt_o) - 1'b1));

    // R4: no tick, no reload -> counter holds
    a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(cnt_o));

endmodule

// File: rtl/wwd_window.sv
module wwd_window
    import wwd_pkg::*;
#(
    parameter int CNT_W = 25,
    parameter int SEL_W = 3
) (
    input  logic [DATA_W-1:0] enc_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              open_o
);

    localparam int NSTEP = 1 << SEL_W;

    logic [CNT_W-1:0] thr [NSTEP];
    logic [SEL_W-1:0] sel;

    for (genvar g = 0; g < NSTEP; g++) begin : g_thr
        assign thr[g] = reload_i >> g;
    end

    assign sel    = SEL_W'(win_shift(enc_i));
    assign open_o = (cnt_i < thr[sel]);

endmodule

// File: rtl/wwd_fsm.sv
module wwd_fsm
    import wwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_wr_i,
    input  logic              key_wr_i,
    input  logic [DATA_W-1:0] key_i,
    input  logic              win_open_i,
    input  logic              expire_i,
    output logic              armed_o,
    output logic              svc_ok_o,
    output logic              violation_o
);

    wd_state_t state_q, state_d;
    logic      second_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_DISARMED;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        armed_o     = (state_q != S_DISARMED);
        second_hit  = (state_q == S_PRIMED) && key_wr_i && (key_i == KEY_SECOND);
        svc_ok_o    = second_hit && win_open_i;
        violation_o = (second_hit && !win_open_i) || (expire_i && !svc_ok_o);
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_DISARMED: begin
                if (arm_wr_i)
                    state_d = S_ARMED;
            end
            S_ARMED: begin
                if (key_wr_i && (key_i == KEY_FIRST))
                    state_d = S_PRIMED;
            end
            S_PRIMED: begin
                if (key_wr_i) begin
                    if (key_i == KEY_SECOND)
                        state_d = S_ARMED;
                    else if (key_i == KEY_FIRST)
                        state_d = S_PRIMED;
                    else if (!win_open_i)
                        state_d = S_ARMED;
                end
            end
            default: state_d = S_DISARMED;
        endcase
        if (violation_o)
            state_d = S_ARMED;
    end

    // R3: only reset returns to the disarmed state
    a_r3_stays_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_DISARMED) |=> (state_q != S_DISARMED));

    // R9: a pending first key exists only after it was written while armed
    a_r9_primed_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(state_q == S_PRIMED)) |-> ($past(key_wr_i) && ($past(key_i) == KEY_FIRST)));

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
    import wwd_pkg::*;
#(
    parameter int PRE_W     = 12,
    parameter int PRE_SHIFT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              nmi_o,
    output logic              rst_req_o
);

    localparam int               CNT_W      = PRE_W + PRE_SHIFT;
    localparam logic [CNT_W-1:0] RST_RELOAD = {{PRE_W{1'b1}}, {PRE_SHIFT{1'b0}}};

    logic [PRE_W-1:0]  preload_q;
    logic [DATA_W-1:0] win_enc_q;
    logic [3:0]        react_q;
    logic              flag_q, nmi_q, rstreq_q;

    logic [CNT_W-1:0]  reload, cnt;
    logic              zero, win_open, armed, svc_ok, violation;
    logic              cfg_wr, arm_wr, key_wr, stat_clr, expire, load;

    assign reload   = {preload_q, {PRE_SHIFT{1'b0}}};
    assign cfg_wr   = bus_wr_i && !armed;
    assign arm_wr   = bus_wr_i && (bus_addr_i == OFS_CTRL) && (bus_wdata_i == ARM_WORD);
    assign key_wr   = bus_wr_i && (bus_addr_i == OFS_KEY);
    assign stat_clr = bus_wr_i && (bus_addr_i == OFS_STAT) && bus_wdata_i[1];
    assign expire   = armed && tick_i && zero;
    assign load     = !armed || svc_ok || violation;

    wwd_counter #(.CNT_W(CNT_W), .RST_VAL(RST_RELOAD)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .load_i   (load),
        .reload_i (reload),
        .cnt_o    (cnt),
        .zero_o   (zero)
    );

    wwd_window #(.CNT_W(CNT_W)) u_window (
        .enc_i    (win_enc_q),
        .reload_i (reload),
        .cnt_i    (cnt),
        .open_o   (win_open)
    );

    wwd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_wr_i    (arm_wr),
        .key_wr_i    (key_wr),
        .key_i       (bus_wdata_i),
        .win_open_i  (win_open),
        .expire_i    (expire),
        .armed_o     (armed),
        .svc_ok_o    (svc_ok),
        .violation_o (violation)
    );

    // configuration, frozen once armed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preload_q <= '1;
            win_enc_q <= WIN_RESET;
            react_q   <= '0;
        end else if (cfg_wr) begin
            if (bus_addr_i == OFS_PRE)   preload_q <= bus_wdata_i[PRE_W-1:0];
            if (bus_addr_i == OFS_WIN)   win_enc_q <= bus_wdata_i;
            if (bus_addr_i == OFS_REACT) react_q   <= bus_wdata_i[3:0];
        end
    end

    // status flag and reactions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q   <= 1'b0;
            nmi_q    <= 1'b0;
            rstreq_q <= 1'b0;
        end else begin
            if (violation)     flag_q <= 1'b1;
            else if (stat_clr) flag_q <= 1'b0;
            nmi_q    <= violation && (react_q == REACT_NMI);
            rstreq_q <= rstreq_q || (violation && (react_q != REACT_NMI));
        end
    end

    assign nmi_o     = nmi_q;
    assign rst_req_o = rstreq_q;

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            OFS_CTRL:  bus_rdata_o = armed ? ARM_WORD : '0;
            OFS_PRE:   bus_rdata_o = DATA_W'(preload_q);
            OFS_STAT:  bus_rdata_o = {{(DATA_W-2){1'b0}}, flag_q, 1'b0};
            OFS_CNT:   bus_rdata_o = DATA_W'(cnt);
            OFS_REACT: bus_rdata_o = DATA_W'(react_q);
            OFS_WIN:   bus_rdata_o = win_enc_q;
            default:   bus_rdata_o = '0;
        endcase
    end

    // R11: violation always leaves the flag set
    a_r11_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> flag_q);

    // R11: flag only drops through a status clear write
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !stat_clr) |=> flag_q);

    // R10: reset request is held until reset
    a_r10_rst_level: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> rst_req_o);

    // R10: interrupt choice pulses after a violation
    a_r10_nmi_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (violation && (react_q == REACT_NMI)) |=> nmi_o);

    // R7: a violation reloads the counter
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> (cnt == $past(reload)));

endmodule

// File: tb/window_watchdog_bench.sv
module window_watchdog_bench;
    import wwd_pkg::*;

    localparam int PW = 12;
    localparam int SH = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              nmi, rst_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    window_watchdog #(.PRE_W(PW), .PRE_SHIFT(SH)) u_window_watchdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .nmi_o       (nmi),
        .rst_req_o   (rst_req)
    );

    function automatic logic [31:0] f_reload(input int unsigned p);
        return 32'(p << SH);
    endfunction

    function automatic int unsigned f_k(input logic [31:0] e);
        case (e)
            32'h50:     return 1;
            32'h500:    return 2;
            32'h5000:   return 3;
            32'h50000:  return 4;
            32'h500000: return 5;
            default:    return 1;
        endcase
    endfunction

    function automatic logic [31:0] f_thr(input int unsigned p, input logic [31:0] e);
        return f_reload(p) >> f_k(e);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_cnt(input logic [31:0] v);
        bus_addr = OFS_CNT;
        #0.5;
        while (bus_rdata != v) begin
            @(negedge clk);
            #0.5;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_wr = 1'b0; tick = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic service();
        wr(OFS_KEY, KEY_FIRST);
        wr(OFS_KEY, KEY_SECOND);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2024));

        do_reset();
        // R1 reset state
        rd(OFS_CTRL, d); chk("R1 ctrl", d, 0);
        rd(OFS_STAT, d); chk("R1 status", d, 0);
        rd(OFS_WIN, d);  chk("R1 window", d, 32'h50);
        rd(OFS_CNT, d);  chk("R1 count", d, f_reload(4095));
        chk("R1 outputs", {30'd0, nmi, rst_req}, 0);

        // R2 wrong arm word ignored
        wr(OFS_CTRL, 32'h12345678);
        rd(OFS_CTRL, d); chk("R2 bad arm ctrl", d, 0);
        @(negedge clk);
        rd(OFS_CNT, d);  chk("R2 bad arm count", d, f_reload(4095));

        wr(OFS_PRE, 2); wr(OFS_WIN, 32'h5000); wr(OFS_REACT, 32'hA);
        rd(OFS_PRE, d); chk("R3 preload before arm", d, 2);
        wr(OFS_CTRL, ARM_WORD);
        rd(OFS_CTRL, d); chk("R2 armed ctrl", d, ARM_WORD);
        rd(OFS_CNT, d);  chk("R4 loaded on arm", d, f_reload(2));
        @(negedge clk);
        rd(OFS_CNT, d);  chk("R4 one step", d, f_reload(2) - 1);
        tick = 1'b0;
        repeat (4) @(negedge clk);
        rd(OFS_CNT, d);  chk("R4 hold without tick", d, f_reload(2) - 1);
        tick = 1'b1;

        // R3 locked after arming
        wr(OFS_PRE, 5);    rd(OFS_PRE, d);   chk("R3 preload locked", d, 2);
        wr(OFS_CTRL, 0);   rd(OFS_CTRL, d);  chk("R3 no disarm", d, ARM_WORD);
        wr(OFS_REACT, 0);  rd(OFS_REACT, d); chk("R3 reaction locked", d, 32'hA);
        wr(OFS_WIN, 32'h50); rd(OFS_WIN, d); chk("R3 window locked", d, 32'h5000);

        // R5 service at first open count (threshold 64)
        wait_cnt(f_thr(2, 32'h5000));
        service();
        rd(OFS_CNT, d);  chk("R5 reload on service", d, f_reload(2));
        rd(OFS_STAT, d); chk("R5 no violation", d, 0);

        // R7 one count early
        wait_cnt(f_thr(2, 32'h5000) + 1);
        service();
        chk("R7/R10 nmi pulse", {31'd0, nmi}, 1);
        rd(OFS_STAT, d); chk("R7/R11 flag", d, 2);
        rd(OFS_CNT, d);  chk("R7 reload", d, f_reload(2));
        @(negedge clk);
        chk("R10 pulse one cycle", {31'd0, nmi}, 0);
        chk("R10 no reset level for nmi", {31'd0, rst_req}, 0);
        rd(OFS_STAT, d); chk("R11 sticky", d, 2);
        wr(OFS_STAT, 2);
        rd(OFS_STAT, d); chk("R11 clear", d, 0);

        // R9 lone second key
        wait_cnt(64);
        wr(OFS_KEY, KEY_SECOND);
        rd(OFS_CNT, d);  chk("R9 lone second key", d, 63);
        rd(OFS_STAT, d); chk("R9 lone second key flag", d, 0);
        service();
        rd(OFS_CNT, d);  chk("R5 service after lone key", d, f_reload(2));

        // R9 wrong word in closed window cancels
        wait_cnt(69);
        wr(OFS_KEY, KEY_FIRST);
        wr(OFS_KEY, 32'h1234);
        wr(OFS_KEY, KEY_SECOND);
        rd(OFS_CNT, d);  chk("R9 cancel no reload", d, 66);
        rd(OFS_STAT, d); chk("R9 cancel no violation", d, 0);

        // R9 wrong word in open window ignored
        wait_cnt(64);
        wr(OFS_KEY, KEY_FIRST);
        wr(OFS_KEY, 32'h1234);
        wr(OFS_KEY, KEY_SECOND);
        rd(OFS_CNT, d);  chk("R9 open ignore then service", d, f_reload(2));
        rd(OFS_STAT, d); chk("R9 open ignore flag", d, 0);

        // R8 expiry with interrupt
        wait_cnt(0);
        @(negedge clk);
        chk("R8 expiry nmi", {31'd0, nmi}, 1);
        rd(OFS_STAT, d); chk("R8 expiry flag", d, 2);
        rd(OFS_CNT, d);  chk("R8 expiry reload", d, f_reload(2));

        // R6 undefined encoding, reset reaction
        do_reset();
        wr(OFS_PRE, 1); wr(OFS_WIN, 32'h123); wr(OFS_REACT, 0);
        wr(OFS_CTRL, ARM_WORD);
        wait_cnt(f_thr(1, 32'h123) + 1);
        service();
        chk("R6/R10 undefined early reset", {31'd0, rst_req}, 1);
        chk("R10 no nmi for reset choice", {31'd0, nmi}, 0);
        repeat (3) @(negedge clk);
        chk("R10 reset level held", {31'd0, rst_req}, 1);
        wr(OFS_STAT, 2);
        wait_cnt(f_thr(1, 32'h123));
        service();
        rd(OFS_STAT, d); chk("R6 undefined open accept", d, 0);
        rd(OFS_CNT, d);  chk("R6 undefined reload", d, f_reload(1));
        wait_cnt(0);
        @(negedge clk);
        rd(OFS_STAT, d); chk("R8 expiry reset choice", d, 2);
        chk("R10 still held", {31'd0, rst_req}, 1);
        do_reset();
        chk("R1 reset clears request", {31'd0, rst_req}, 0);
        rd(OFS_CTRL, d); chk("R3 reset disarms", d, 0);

        // random windows and preloads
        for (int i = 0; i < 12; i++) begin
            int unsigned p, kk;
            logic [31:0] enc;
            logic sel_nmi;
            p = 1 + ($urandom % 7);
            kk = $urandom % 5;
            enc = 32'h50 << (4 * kk);
            sel_nmi = 1'($urandom % 2);
            do_reset();
            wr(OFS_PRE, p); wr(OFS_WIN, enc); wr(OFS_REACT, sel_nmi ? 32'hA : 32'h3);
            wr(OFS_CTRL, ARM_WORD);
            wait_cnt(f_thr(p, enc));
            service();
            rd(OFS_STAT, d); chk("R6 random open accept", d, 0);
            rd(OFS_CNT, d);  chk("R5 random reload", d, f_reload(p));
            wait_cnt(f_thr(p, enc) + 1);
            service();
            rd(OFS_STAT, d); chk("R7 random early flag", d, 2);
            chk("R10 random reaction", {30'd0, nmi, rst_req}, sel_nmi ? 32'd2 : 32'd1);
        end

        summary();
        $finish;
    end

endmodule